// File: doc/BRIEF.md
# Drive Ready and Seek Watchdog

This block decides when a disc drive may be reported as ready, and it supervises each carriage seek. It looks at four inputs: heads-loaded, the load switch, a position-match level that stays high while a seek is still under way, and a one-cycle pulse that clears attention when the controller issues a new cylinder address. From these it produces the drive-ready, access-ready, attention, first-status and drive-fault levels, two active-low lamp drives, and a retract request for the servo electronics.

Two state machines do the work. The readiness machine has four states: `RDY_IDLE`, `RDY_DELAY`, `RDY_ONLINE` and `RDY_FAULT`. Its transitions are as follows:
- IDLE to DELAY when heads-loaded and the load switch are both high.
- DELAY to ONLINE when the ready delay expires.
- DELAY or ONLINE to FAULT when the seek watchdog has expired.
- Any state back to IDLE when either enable input drops.

The seek machine has three states: `SK_HOLD`, `SK_RUN` and `SK_EXPIRED`. Its transitions are as follows:
- HOLD to RUN when position-match and heads-loaded are both high.
- RUN to EXPIRED when the timeout count completes.
- RUN or EXPIRED back to HOLD as soon as either of those inputs is low.

The ready delay and the seek timeout are given in clock cycles. The defaults are 100 ms and 850 ms at 100 MHz.

Top module: `drive_ready_watchdog`

## Requirements
- R1: With heads_loaded and load_switch both high, drive_ready rises on the (READY_DELAY_CYC+1)-th rising edge that samples both high, and not earlier.
- R2: When heads_loaded or load_switch is low at a rising edge, drive_ready and drive_fault are both low after that edge.
- R3: first_status is set at any edge that sees drive_ready low. Once set, only the synchronous reset clears it.
- R4: access_ready equals drive_ready AND NOT position_match.
- R5: attention is set at an edge where drive_ready is high, position_match is low and set_cyl_clr is low.
- R6: set_cyl_clr high at an edge clears attention. The clear takes priority over the set condition.
- R7: The seek timer counts only while position_match and heads_loaded are both high. A low on either input discards the count, so no fault arises from seeks shorter than the timeout.
- R8: If position_match and heads_loaded stay high for SEEK_TIMEOUT_CYC+2 consecutive edges while the drive is enabled, drive_fault rises at the last of those edges and not before.
- R9: While drive_fault is high: drive_ready is low, ready_lamp_n is high, fault_lamp_n is low, retract_req is high and access_ready is low.
- R10: drive_fault stays set while heads_loaded and load_switch remain high, even after position_match falls. It clears when either input drops, and ready then returns only after a fresh ready delay.
- R11: While rst is high, every active-high output is 0 and both lamp outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| heads_loaded | input | 1 | Heads are loaded over the disc |
| load_switch | input | 1 | Operator load switch is on |
| position_match | input | 1 | High while a seek is pending (carriage not yet on target) |
| set_cyl_clr | input | 1 | One-cycle pulse on a new cylinder command; clears attention |
| drive_ready | output | 1 | Drive is ready |
| access_ready | output | 1 | Ready and no seek pending |
| attention | output | 1 | Latched attention request to the controller |
| first_status | output | 1 | Latched: drive has been not-ready since reset |
| drive_fault | output | 1 | Latched seek timeout fault |
| ready_lamp_n | output | 1 | Ready lamp drive, active low |
| fault_lamp_n | output | 1 | Fault lamp drive, active low |
| retract_req | output | 1 | Request to the servo to retract the carriage |

## Verification
The embedded properties check several rules on every cycle:
- Ready and fault fall one edge after an enable input drops.
- A fault rises only after the seek timer has expired, and stays set while the drive remains enabled.
- The timer cannot be expired once its run condition is gone.
- The attention clear wins over the set, and first-status is sticky.

The exact cycle counts need the bench's scenarios and its cycle-accurate reference model:
- The ready delay length.
- The timeout after SEEK_TIMEOUT_CYC+2 edges.
- The restart of the timer after a short seek.
- Recovery through a new ready delay after a fault.

// File: rtl/drw_pkg.sv
package drw_pkg;

    typedef enum logic [1:0] {
        RDY_IDLE   = 2'd0,
        RDY_DELAY  = 2'd1,
        RDY_ONLINE = 2'd2,
        RDY_FAULT  = 2'd3
    } rdy_state_t;

    typedef enum logic [1:0] {
        SK_HOLD    = 2'd0,
        SK_RUN     = 2'd1,
        SK_EXPIRED = 2'd2
    } sk_state_t;

endpackage

// File: rtl/drw_seek_timer.sv
module drw_seek_timer
    import drw_pkg::*;
#(
    parameter int unsigned TMO_CYC = 85_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic heads_loaded,
    input  logic position_match,
    output logic expired
);

    localparam int unsigned CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

    sk_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          run_ok;

    assign run_ok = position_match & heads_loaded;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SK_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SK_HOLD: begin
                if (run_ok) begin
                    state_d = SK_RUN;
                    cnt_d   = '0;
                end
            end
            SK_RUN: begin
                if (!run_ok) begin
                    state_d = SK_HOLD;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = SK_EXPIRED;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SK_EXPIRED: begin
                if (!run_ok) begin
                    state_d = SK_HOLD;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = SK_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        expired = (state_q == SK_EXPIRED);
    end

    // R7: no expiry survives a missing run condition
    p_timer_inhibit_r7: assert property (@(posedge clk) disable iff (rst)
        !(position_match && heads_loaded) |=> !expired);

    // R8: count never passes the timeout limit
    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/drw_ready_fsm.sv
module drw_ready_fsm
    import drw_pkg::*;
#(
    parameter int unsigned DLY_CYC = 10_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic heads_loaded,
    input  logic load_switch,
    input  logic seek_expired,
    output logic drive_ready,
    output logic drive_fault
);

    localparam int unsigned CW = $clog2(DLY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DLY_CYC - 1);

    rdy_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          enable_w;

    assign enable_w = heads_loaded & load_switch;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RDY_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RDY_IDLE: begin
                if (enable_w) begin
                    state_d = RDY_DELAY;
                    cnt_d   = '0;
                end
            end
            RDY_DELAY: begin
                if (!enable_w) begin
                    state_d = RDY_IDLE;
                end else if (seek_expired) begin
                    state_d = RDY_FAULT;
                end else if (cnt_q == LAST) begin
                    state_d = RDY_ONLINE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            RDY_ONLINE: begin
                if (!enable_w) begin
                    state_d = RDY_IDLE;
                end else if (seek_expired) begin
                    state_d = RDY_FAULT;
                end
            end
            RDY_FAULT: begin
                if (!enable_w) begin
                    state_d = RDY_IDLE;
                end
            end
            default: state_d = RDY_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        drive_ready = (state_q == RDY_ONLINE);
        drive_fault = (state_q == RDY_FAULT);
    end

    // R2: losing either enable input drops ready and fault
    p_enable_drop_r2: assert property (@(posedge clk) disable iff (rst)
        !enable_w |=> (!drive_ready && !drive_fault));

    // R1: ready only rises while the drive stays enabled
    p_ready_rise_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_ready) |-> $past(enable_w));

    // R8: a fault is always preceded by an expired seek timer
    p_fault_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_fault) |-> $past(seek_expired));

    // R10: fault holds while the drive stays enabled
    p_fault_latch_r10: assert property (@(posedge clk) disable iff (rst)
        (drive_fault && enable_w) |=> drive_fault);

endmodule

// File: rtl/drw_status_flags.sv
module drw_status_flags (
    input  logic clk,
    input  logic rst,
    input  logic drive_ready,
    input  logic position_match,
    input  logic set_cyl_clr,
    output logic attention,
    output logic first_status
);

    always_ff @(posedge clk) begin
        if (rst) begin
            attention <= 1'b0;
        end else if (set_cyl_clr) begin
            attention <= 1'b0;
        end else if (drive_ready && !position_match) begin
            attention <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            first_status <= 1'b0;
        end else if (!drive_ready) begin
            first_status <= 1'b1;
        end
    end

    // R6: the clear pulse wins over the set condition
    p_attn_clear_r6: assert property (@(posedge clk) disable iff (rst)
        set_cyl_clr |=> !attention);

    // R5: ready with no pending seek raises attention
    p_attn_set_r5: assert property (@(posedge clk) disable iff (rst)
        (drive_ready && !position_match && !set_cyl_clr) |=> attention);

    // R3: not-ready sets first-status, which then sticks
    p_first_set_r3: assert property (@(posedge clk) disable iff (rst)
        !drive_ready |=> first_status);
    p_first_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        first_status |=> first_status);

endmodule

// File: rtl/drive_ready_watchdog.sv
module drive_ready_watchdog #(
    parameter int unsigned READY_DELAY_CYC  = 10_000_000,
    parameter int unsigned SEEK_TIMEOUT_CYC = 85_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic heads_loaded,
    input  logic load_switch,
    input  logic position_match,
    input  logic set_cyl_clr,
    output logic drive_ready,
    output logic access_ready,
    output logic attention,
    output logic first_status,
    output logic drive_fault,
    output logic ready_lamp_n,
    output logic fault_lamp_n,
    output logic retract_req
);

    logic seek_expired;
    logic ready_w;
    logic fault_w;

    drw_seek_timer #(.TMO_CYC(SEEK_TIMEOUT_CYC)) seek_i (
        .clk            (clk),
        .rst            (rst),
        .heads_loaded   (heads_loaded),
        .position_match (position_match),
        .expired        (seek_expired)
    );

    drw_ready_fsm #(.DLY_CYC(READY_DELAY_CYC)) ready_i (
        .clk          (clk),
        .rst          (rst),
        .heads_loaded (heads_loaded),
        .load_switch  (load_switch),
        .seek_expired (seek_expired),
        .drive_ready  (ready_w),
        .drive_fault  (fault_w)
    );

    drw_status_flags flags_i (
        .clk            (clk),
        .rst            (rst),
        .drive_ready    (ready_w),
        .position_match (position_match),
        .set_cyl_clr    (set_cyl_clr),
        .attention      (attention),
        .first_status   (first_status)
    );

    // outputs
    always_comb begin
        drive_ready  = ready_w;
        drive_fault  = fault_w;
        access_ready = ready_w & ~position_match;
        ready_lamp_n = ~ready_w;
        fault_lamp_n = ~fault_w;
        retract_req  = fault_w;
    end

    // R9: a retract request always comes with ready withdrawn
    p_retract_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
        retract_req |-> (!drive_ready && !access_ready));

endmodule

// File: tb/drive_ready_watchdog_tb_top.sv
module drive_ready_watchdog_tb_top;

    localparam int D = 4;
    localparam int T = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hl = 1'b0, ls = 1'b0, pm = 1'b0, clr = 1'b0;
    logic drive_ready, access_ready, attention, first_status;
    logic drive_fault, ready_lamp_n, fault_lamp_n, retract_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    drive_ready_watchdog #(.READY_DELAY_CYC(D), .SEEK_TIMEOUT_CYC(T)) dut_i (
        .clk (clk), .rst (rst),
        .heads_loaded (hl), .load_switch (ls),
        .position_match (pm), .set_cyl_clr (clr),
        .drive_ready (drive_ready), .access_ready (access_ready),
        .attention (attention), .first_status (first_status),
        .drive_fault (drive_fault), .ready_lamp_n (ready_lamp_n),
        .fault_lamp_n (fault_lamp_n), .retract_req (retract_req)
    );

    // behavioural reference model
    int m_en_cnt = 0, m_seek_cnt = 0;
    bit m_ready = 0, m_fault = 0, m_exp = 0, m_attn = 0, m_first = 0;

    always @(posedge clk) begin
        bit en, f_new, e_new, r_new;
        int en_new, sk_new;
        if (rst) begin
            m_en_cnt = 0; m_seek_cnt = 0; m_ready = 0; m_fault = 0;
            m_exp = 0; m_attn = 0; m_first = 0;
        end else begin
            en     = hl && ls;
            en_new = en ? m_en_cnt + 1 : 0;
            sk_new = (pm && hl) ? m_seek_cnt + 1 : 0;
            e_new  = (sk_new >= T + 1);
            f_new  = en && (m_fault || (m_exp && m_en_cnt >= 1));
            r_new  = en && !f_new && (en_new >= D + 1);
            if (clr) m_attn = 0;
            else if (m_ready && !pm) m_attn = 1;
            if (!m_ready) m_first = 1;
            m_en_cnt = en_new; m_seek_cnt = sk_new;
            m_exp = e_new; m_fault = f_new; m_ready = r_new;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_eq(input string tag, input string what, input logic act, input bit exp);
        chk(act === exp, tag, what, int'(act), int'(exp));
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (!done) begin
            chk_eq("R1", "drive_ready", drive_ready, m_ready);
            chk_eq("R3", "first_status", first_status, m_first);
            chk_eq("R4", "access_ready", access_ready, m_ready && !pm);
            chk_eq("R5", "attention", attention, m_attn);
            chk_eq("R8", "drive_fault", drive_fault, m_fault);
            chk_eq("R9", "ready_lamp_n", ready_lamp_n, !m_ready);
            chk_eq("R9", "fault_lamp_n", fault_lamp_n, !m_fault);
            chk_eq("R9", "retract_req", retract_req, m_fault);
        end
    end

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #3;
    endtask

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        edges(3);
        // R11: reset state
        chk_eq("R11", "drive_ready", drive_ready, 0);
        chk_eq("R11", "drive_fault", drive_fault, 0);
        chk_eq("R11", "attention", attention, 0);
        chk_eq("R11", "first_status", first_status, 0);
        chk_eq("R11", "access_ready", access_ready, 0);
        chk_eq("R11", "retract_req", retract_req, 0);
        chk_eq("R11", "ready_lamp_n", ready_lamp_n, 1);
        chk_eq("R11", "fault_lamp_n", fault_lamp_n, 1);

        // R1: ready delay
        rst = 0; hl = 1; ls = 1; pm = 0;
        edges(D);
        chk_eq("R1", "ready before delay", drive_ready, 0);
        chk_eq("R3", "first_status", first_status, 1);
        edges(1);
        chk_eq("R1", "ready after delay", drive_ready, 1);
        chk_eq("R9", "ready_lamp_n", ready_lamp_n, 0);
        edges(1);
        chk_eq("R5", "attention set", attention, 1);
        chk_eq("R4", "access_ready", access_ready, 1);

        // R6: clear with seek start
        pm = 1; clr = 1;
        edges(1);
        chk_eq("R6", "attention cleared", attention, 0);
        chk_eq("R4", "access_ready low in seek", access_ready, 0);
        clr = 0;
        edges(8);
        chk_eq("R6", "attention stays clear", attention, 0);
        pm = 0;
        edges(1);
        chk_eq("R5", "attention after seek", attention, 1);

        // R7: short seeks restart the timer
        pm = 1; edges(15);
        pm = 0; edges(1);
        pm = 1; edges(15);
        chk_eq("R7", "no fault on short seeks", drive_fault, 0);
        pm = 0; edges(2);

        // R8: timeout
        pm = 1;
        edges(T + 1);
        chk_eq("R8", "no fault before timeout", drive_fault, 0);
        edges(1);
        chk_eq("R8", "fault at timeout", drive_fault, 1);
        chk_eq("R9", "ready withdrawn", drive_ready, 0);
        chk_eq("R9", "retract_req", retract_req, 1);
        chk_eq("R9", "fault_lamp_n", fault_lamp_n, 0);
        chk_eq("R9", "ready_lamp_n", ready_lamp_n, 1);

        // R10: latched fault and recovery
        edges(10);
        chk_eq("R10", "fault held", drive_fault, 1);
        pm = 0; edges(3);
        chk_eq("R10", "fault held after arrival", drive_fault, 1);
        ls = 0; edges(1);
        chk_eq("R10", "fault cleared by load switch", drive_fault, 0);
        chk_eq("R2", "ready low", drive_ready, 0);
        ls = 1; edges(D);
        chk_eq("R10", "no ready before new delay", drive_ready, 0);
        edges(1);
        chk_eq("R10", "ready after new delay", drive_ready, 1);

        // R2: heads unload
        hl = 0; edges(1);
        chk_eq("R2", "ready drops on heads unload", drive_ready, 0);
        hl = 1; edges(D + 2);
        chk_eq("R1", "ready again", drive_ready, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule